// File: doc/BRIEF.md
# Cartridge ROM Transfer Timing Controller

This block paces a command-then-data read from a cartridge ROM bus. Software writes a 32-bit control word. When the word has its start bit set and the interface is enabled, the block times out a command phase. It then either ends at once for a transfer with no data, or hands out 32-bit data words one at a time. Each word is latched from an external word source. Its arrival sets a ready flag in the control word and pulses a DMA request. The next word is timed only after the current one has been read from the data port.

All delays are counted in transfer units of 5 or 8 clocks. The command phase lasts 8 plus a 13-bit latency field. A 6-bit gap field is added to it when data follows. Every later word takes 4 units, plus the gap again whenever the number of bytes already delivered is a multiple of 512. When the last word has been read, the block clears its busy bit and can pulse an interrupt. A single down-counter holds the one pending event.

Top module: `cart_xfer_ctl`

## Requirements
- R1: After reset the control word reads 0, and `dma_req`, `irq` and `src_next` are low.
- R2: A control write stores `ctl_wdata & 0xFF7F7FFF`, except that bit 23 (word ready) keeps its previous value. Software can neither set nor clear bit 23.
- R3: A write starts a transfer only when bit 31 of the written value is 1 and `iface_en` is 1. Any other write only stores the value, and no word, DMA request or interrupt follows from it.
- R4: The transfer unit is 8 clocks when bit 27 is 1 and 5 clocks when it is 0. The command latency is 8 plus bits 12:0, with bits 21:16 (the gap) added only when the data size is non-zero.
- R5: Bits 26:24 give the data size: code 0 is 0 bytes, code 7 is 4 bytes, and codes 1 to 6 are 256 shifted left by the code (code 2 gives 1024 bytes, 256 words).
- R6: With a zero data size, bit 31 clears exactly unit × latency clocks after the starting write edge. At the same edge `irq` pulses for one clock if `irq_en` is 1, and stays low otherwise.
- R7: With a non-zero size, the first word is ready unit × (latency + 4) clocks after the starting write edge. At that edge bit 23 sets, `rd_word` takes `src_data`, and `dma_req` and `src_next` each pulse for one clock.
- R8: A `data_rd` while bit 23 is 1 clears bit 23. If data remains, the next word is ready unit × 4 clocks after that edge, plus unit × gap when the bytes delivered so far are a multiple of 512.
- R9: A `data_rd` while bit 23 is 1 and no data remains clears bit 31 at that edge and pulses `irq` if `irq_en` is 1. A `data_rd` while bit 23 is 0, or in the same clock as `ctl_wr`, has no effect.
- R10: A starting write clears bit 23 at its edge, even if a word was waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable; gates the start of a transfer |
| irq_en | input | 1 | Allows the end-of-transfer interrupt |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Current control word |
| data_rd | input | 1 | Data port read strobe |
| rd_word | output | 32 | Most recently delivered data word |
| src_data | input | 32 | Word offered by the data source |
| src_next | output | 1 | Pulse: the offered word was taken |
| dma_req | output | 1 | Pulse: a new word is ready |
| irq | output | 1 | Pulse: transfer finished with interrupt enabled |

## Verification
The zero-size transfer is run twice, once with fast units and a non-zero gap and once with slow units, latency zero and the interrupt disabled. Together the two runs show that the gap is left out of a data-less command, that the unit scales the latency, and that the interrupt is gated. A 4-byte transfer with slow units tests first-word latency with the gap included, a restart over a waiting word, the retention of bit 23 across writes, the end on the final read, and a read that should be ignored. A 1024-byte transfer with fast units times all 256 words. Only the interval after byte 512 carries the gap, so this run separates re-insertion at the 512-byte boundary from a gap applied once or every time. A start attempt with the interface disabled must produce no activity.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
  localparam int CMD_W   = 13;
  localparam int GAP_W   = 6;
  localparam int GAP_LSB = 16;
  localparam int RDY_B   = 23;
  localparam int SIZ_LSB = 24;
  localparam int SLOW_B  = 27;
  localparam int BUSY_B  = 31;
  localparam logic [31:0] WR_MASK = 32'hFF7F7FFF;

  typedef enum logic [1:0] {EV_NONE, EV_WORD, EV_END} ev_kind_t;

  function automatic int unsigned size_of(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd7:    return 4;
      default: return 32'd256 << code;
    endcase
  endfunction
endpackage

// File: rtl/cxf_delay_timer.sv
module cxf_delay_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             act;

  assign fire = act && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      act <= 1'b1;
      cnt <= load_val;
    end else if (act) begin
      if (fire) act <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cxf_timing_calc.sv
module cxf_timing_calc
  import cxf_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int POS_W = 15
) (
  input  logic             slow,
  input  logic [CMD_W-1:0] cmd_lat,
  input  logic [GAP_W-1:0] gap,
  input  logic [2:0]       size_code,
  input  logic [8:0]       pos_low,
  output logic [POS_W-1:0] size,
  output logic             is_end,
  output logic [CNT_W-1:0] first_dly,
  output logic [CNT_W-1:0] next_dly
);
  localparam int LAT_W = CMD_W + 2;

  logic [LAT_W-1:0] lat, first_u, next_u;

  function automatic logic [CNT_W-1:0] scale(input logic [LAT_W-1:0] u, input logic s);
    logic [CNT_W-1:0] w;
    w = CNT_W'(u);
    return s ? (w << 3) : ((w << 2) + w);
  endfunction

  always_comb begin
    size      = POS_W'(size_of(size_code));
    is_end    = (size == '0);
    lat       = LAT_W'(8) + LAT_W'(cmd_lat) + (is_end ? '0 : LAT_W'(gap));
    first_u   = is_end ? lat : lat + LAT_W'(4);
    next_u    = LAT_W'(4) + ((pos_low == 9'd0) ? LAT_W'(gap) : '0);
    first_dly = scale(first_u, slow);
    next_dly  = scale(next_u, slow);
  end
endmodule

// File: rtl/cart_xfer_ctl.sv
module cart_xfer_ctl
  import cxf_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int POS_W = 15,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iface_en,
  input  logic          irq_en,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic          data_rd,
  output logic [DW-1:0] rd_word,
  input  logic [DW-1:0] src_data,
  output logic          src_next,
  output logic          dma_req,
  output logic          irq
);
  logic [31:0]      ctl, wmask, cfg;
  logic [POS_W-1:0] pos, size, calc_size;
  ev_kind_t         kind;
  logic             start, rd_ok, more, fire, t_load, calc_end;
  logic [CNT_W-1:0] first_dly, next_dly;

  assign wmask = (ctl_wdata & WR_MASK) | (ctl & (32'd1 << RDY_B));
  assign start = ctl_wr && iface_en && ctl_wdata[BUSY_B];
  assign rd_ok = data_rd && !ctl_wr && ctl[RDY_B];
  assign more  = pos < size;
  assign cfg   = ctl_wr ? wmask : ctl;
  assign t_load = start || (rd_ok && more);

  cxf_timing_calc #(.CNT_W(CNT_W), .POS_W(POS_W)) u_calc (
    .slow      (cfg[SLOW_B]),
    .cmd_lat   (cfg[CMD_W-1:0]),
    .gap       (cfg[GAP_LSB +: GAP_W]),
    .size_code (cfg[SIZ_LSB +: 3]),
    .pos_low   (pos[8:0]),
    .size      (calc_size),
    .is_end    (calc_end),
    .first_dly (first_dly),
    .next_dly  (next_dly)
  );

  cxf_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (start ? first_dly : next_dly),
    .fire     (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      pos      <= '0;
      size     <= '0;
      kind     <= EV_NONE;
      rd_word  <= '0;
      dma_req  <= 1'b0;
      src_next <= 1'b0;
      irq      <= 1'b0;
    end else begin
      dma_req  <= 1'b0;
      src_next <= 1'b0;
      irq      <= 1'b0;
      if (fire) begin
        if (kind == EV_WORD) begin
          rd_word    <= src_data;
          pos        <= pos + POS_W'(4);
          ctl[RDY_B] <= 1'b1;
          dma_req    <= 1'b1;
          src_next   <= 1'b1;
        end else if (kind == EV_END) begin
          ctl[BUSY_B] <= 1'b0;
          irq         <= irq_en;
        end
      end
      if (rd_ok) begin
        ctl[RDY_B] <= 1'b0;
        if (more) begin
          kind <= EV_WORD;
        end else begin
          ctl[BUSY_B] <= 1'b0;
          irq         <= irq_en;
        end
      end
      if (ctl_wr) begin
        ctl <= wmask;
        if (start) begin
          ctl[RDY_B] <= 1'b0;
          pos        <= '0;
          size       <= calc_size;
          kind       <= calc_end ? EV_END : EV_WORD;
        end
      end
    end
  end

  assign ctl_rdata = ctl;
endmodule

// File: rtl/cxf_checker.sv
module cxf_checker (
  input logic        clk,
  input logic        rst,
  input logic        iface_en,
  input logic        irq_en,
  input logic        ctl_wr,
  input logic [31:0] ctl_wdata,
  input logic [31:0] ctl_rdata,
  input logic        data_rd,
  input logic        dma_req,
  input logic        irq
);
  // R7: the ready flag only rises together with a DMA request
  a_r7_ready_with_dma: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[23]) |-> dma_req);

  // R7: the DMA request is a single-clock pulse
  a_r7_dma_pulse: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);

  // R6: an interrupt comes with busy already clear
  a_r6_irq_not_busy: assert property (@(posedge clk) disable iff (rst)
    irq |-> !ctl_rdata[31]);

  // R9: an interrupt needs the enable at the ending edge
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R8: a valid read clears the ready flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !ctl_wr && ctl_rdata[23]) |=> !ctl_rdata[23]);

  // R10: a starting write clears the ready flag
  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && iface_en && ctl_wdata[31]) |=> !ctl_rdata[23]);
endmodule

bind cart_xfer_ctl cxf_checker u_chk (
  .clk(clk), .rst(rst), .iface_en(iface_en), .irq_en(irq_en),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .data_rd(data_rd), .dma_req(dma_req), .irq(irq)
);

// File: tb/sim_cart_xfer_ctl.sv
`timescale 1ns/1ps
module sim_cart_xfer_ctl;
  logic        clk = 0, rst = 1;
  logic        iface_en = 0, irq_en = 0, ctl_wr = 0, data_rd = 0;
  logic [31:0] ctl_wdata = 0, ctl_rdata, rd_word, src_data;
  logic        src_next, dma_req, irq;
  int          total = 0, bad = 0, cyc = 0, src_idx = 0;

  always #4 clk = ~clk;

  assign src_data = 32'hC3A50000 ^ (src_idx * 32'h01030507);

  cart_xfer_ctl u0 (.*);

  always @(posedge clk) begin
    if (rst) src_idx <= 0;
    else if (src_next) src_idx <= src_idx + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctl, m_word;
  int  m_cnt, m_pos, m_size, m_kind;
  bit  m_act, m_dma, m_irq, m_take;

  function automatic int dec_size(input int c);
    if (c == 0) return 0;
    if (c == 7) return 4;
    return 256 << c;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] old, w;
    int u, lat, opos;
    bit fire;
    if (rst) begin
      m_ctl = 0; m_word = 0; m_cnt = 0; m_pos = 0; m_size = 0; m_kind = 0;
      m_act = 0; m_dma = 0; m_irq = 0; m_take = 0;
    end else begin
      old = m_ctl; opos = m_pos;
      fire = m_act && m_cnt == 1;
      if (m_act) begin if (m_cnt == 1) m_act = 0; else m_cnt--; end
      m_dma = 0; m_irq = 0; m_take = 0;
      if (fire) begin
        if (m_kind == 0) begin
          m_word = src_data; m_pos += 4; m_ctl[23] = 1; m_dma = 1; m_take = 1;
        end else begin
          m_ctl[31] = 0; m_irq = irq_en;
        end
      end
      if (data_rd && !ctl_wr && old[23]) begin
        m_ctl[23] = 0;
        u = old[27] ? 8 : 5;
        if (opos < m_size) begin
          m_cnt = u * (4 + ((opos % 512 == 0) ? int'(old[21:16]) : 0));
          m_act = 1; m_kind = 0;
        end else begin
          m_ctl[31] = 0; m_irq = irq_en;
        end
      end
      if (ctl_wr) begin
        w = (ctl_wdata & 32'hFF7F7FFF) | (old & 32'h00800000);
        m_ctl = w;
        if (iface_en && ctl_wdata[31]) begin
          m_ctl[23] = 0; m_pos = 0; m_size = dec_size(int'(w[26:24]));
          u = w[27] ? 8 : 5;
          lat = 8 + int'(w[12:0]) + ((m_size != 0) ? int'(w[21:16]) : 0);
          if (m_size == 0) begin m_cnt = u * lat; m_kind = 1; end
          else begin m_cnt = u * (lat + 4); m_kind = 0; end
          m_act = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(ctl_rdata == m_ctl, "R2 ctl word vs model", ctl_rdata, m_ctl);
      chk(rd_word == m_word, "R7 data word vs model", rd_word, m_word);
      chk(dma_req == m_dma && src_next == m_take, "R7 dma/take vs model",
          {dma_req, src_next}, {m_dma, m_take});
      chk(irq == m_irq, "R6 irq vs model", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [31:0] v);
    ctl_wdata = v; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd();
    data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  // which: 0 dma_req, 1 irq, 2 busy low
  task automatic wait_for(input int which, input int lim, output int c);
    c = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if ((which == 0 && dma_req) || (which == 1 && irq) || (which == 2 && !ctl_rdata[31])) begin
        c = i; break;
      end
    end
  endtask

  localparam logic [31:0] A4 = 32'h80000000 | (1 << 27) | (7 << 24) | (3 << 16) | 1;

  initial begin
    int c, words;
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctl_rdata == 0 && !dma_req && !irq && !src_next, "R1 reset state", ctl_rdata, 0);
    iface_en = 1; irq_en = 1;

    wr(32'h7FFFFFFF);
    chk(ctl_rdata == 32'h7F7F7FFF, "R2 write mask", ctl_rdata, 32'h7F7F7FFF);
    wr(0);

    iface_en = 0;
    wr(32'h87000000);
    wait_for(0, 300, c);
    chk(c == -1, "R3 no start when disabled", c, -1);
    chk(ctl_rdata == 32'h87000000, "R3 value stored only", ctl_rdata, 32'h87000000);
    iface_en = 1;
    wr(0);

    wr(32'h803F0002);
    wait_for(1, 200, c);
    chk(c == 50, "R6 zero size end time, gap excluded (R4)", c, 50);
    chk(!ctl_rdata[31], "R6 busy cleared", ctl_rdata[31], 0);

    irq_en = 0;
    wr(32'h88000000);
    wait_for(2, 200, c);
    chk(c == 64, "R6 slow unit zero size (R4)", c, 64);
    chk(!irq, "R6 irq gated off", irq, 0);
    irq_en = 1;

    wr(A4);
    wait_for(0, 400, c);
    chk(c == 128, "R7 first word latency with gap (R4 R5)", c, 128);
    chk(ctl_rdata[23], "R7 ready set", ctl_rdata[23], 1);
    wr(A4);
    chk(!ctl_rdata[23], "R10 restart clears ready", ctl_rdata[23], 0);
    wait_for(0, 400, c);
    chk(c == 128, "R10 restarted latency", c, 128);
    rd();
    chk(irq && !ctl_rdata[31] && !ctl_rdata[23], "R9 last read ends", {irq, ctl_rdata[31]}, 2'b10);
    keep = rd_word;
    rd();
    wait_for(0, 60, c);
    chk(c == -1 && rd_word == keep, "R9 read without ready ignored", c, -1);

    wr(A4);
    wait_for(0, 400, c);
    wr(A4 & 32'h7F7FFFFF);
    chk(ctl_rdata == ((A4 & 32'h7F7FFFFF) | 32'h00800000), "R2 ready kept on write",
        ctl_rdata, (A4 & 32'h7F7FFFFF) | 32'h00800000);
    wr(A4 & 32'h7FFFFFFF);
    chk(ctl_rdata[23], "R2 software cannot clear ready", ctl_rdata[23], 1);
    rd();
    chk(irq, "R9 end irq", irq, 1);

    wr(32'h80000000 | (2 << 24) | (2 << 16));
    wait_for(0, 300, c);
    chk(c == 70, "R7 first word fast unit", c, 70);
    words = (c > 0) ? 1 : 0;
    for (int k = 1; k < 256; k++) begin
      rd();
      wait_for(0, 100, c);
      if (c > 0) words++;
      if (k == 128) chk(c == 30, "R8 gap at 512-byte boundary", c, 30);
      else chk(c == 20, "R8 per-word delay", c, 20);
    end
    chk(words == 256, "R5 code 2 gives 256 words", words, 256);
    rd();
    chk(irq && !ctl_rdata[31], "R9 end after last word", irq, 1);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule